// File: doc/BRIEF.md
# AHB-Lite Central Address Decoder with Response Multiplexer

This block is the single place in an AHB-Lite fabric that turns the address phase of a transfer into slave selects, and that routes the data-phase answer of the chosen slave back to the master. It serves up to `NUM_SLV` slaves plus a built-in default slave. A slave is selected only when two things agree: a board identifier input must equal the slave's configured identifier, and an address field must equal the slave's configured region code. The field is eight bits starting at bit 20 by default.

The live decode drives `hsel` during the address phase. On every clock edge where the bus ready is high, the block stores which target won. During the data phase it uses that stored choice, and never the live decode, to steer read data, ready and response to the master. The same ready is returned to all slaves as `hready`. Addresses that match no slave go to the default slave. For an IDLE or BUSY transfer it answers OKAY with no wait. For a NONSEQ or SEQ transfer it gives a two-cycle ERROR.

Top module: `ahbl_central_dec`

## Requirements
- R1: `hsel[i]` is high in the same cycle when `board_id` equals slave i's identifier and `haddr[FLD_LSB +: FLD_W]` equals slave i's region code. With the default parameters every slave has identifier 4'hC and slave 0 has region 8'h20.
- R2: If either the identifier or the region field differs, slave i is not selected. When no slave matches, `hsel` is all zero and the transfer goes to the default slave.
- R3: At most one `hsel` bit is high. When several slaves match, the one with the lowest index wins.
- R4: The data-phase target is captured on a rising edge only when `hready` is high. While `hready` is low it holds.
- R5: `hrdata`, `hready` and `hresp` follow the captured data-phase target, whatever the live decode shows.
- R6: An unmapped NONSEQ (htrans 2'b10) or SEQ (2'b11) transfer gets ERROR (`hresp` 2'b01) for two data-phase cycles. `hready` is low in the first of these cycles and high in the second. `hrdata` is zero.
- R7: An unmapped IDLE (2'b00) or BUSY (2'b01) transfer gets OKAY (2'b00) with `hready` high in its first data-phase cycle.
- R8: During and after a synchronous reset the data-phase target is the default slave. `hready` is 1, `hresp` is OKAY and `hrdata` is zero.
- R9: A mapped slave's `hresp` code is forwarded unchanged: OKAY 2'b00, ERROR 2'b01, RETRY 2'b10, SPLIT 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| board_id | input | ID_W | Module identifier compared during decode |
| haddr | input | ADDR_W | Address-phase address |
| htrans | input | 2 | Address-phase transfer type |
| hsel | output | NUM_SLV | One-hot live slave selects |
| s_hrdata | input | NUM_SLV*DATA_W | Read data of each slave, slave i at bits i*DATA_W |
| s_hreadyout | input | NUM_SLV | Ready output of each slave |
| s_hresp | input | 2*NUM_SLV | Response of each slave, slave i at bits 2*i |
| hrdata | output | DATA_W | Read data to the master |
| hready | output | 1 | Ready to the master and to all slaves |
| hresp | output | 2 | Response to the master |

## Verification
The bench builds the block with four slaves and gives slave 2 identifier 4'h3. This makes an identifier-only mismatch reachable with a matching region. Slaves 1, 2 and 3 share region 8'h21, so slave 1 and slave 3 overlap completely, which brings the lowest-index priority rule within reach. Region codes other than 8'h20 and 8'h21 exercise the default slave. A slave whose ready is pulled low shows that the captured target holds against a changing live decode.

// File: rtl/ahbl_dec_pkg.sv
package ahbl_dec_pkg;

  typedef enum logic [1:0] {
    RSP_OKAY  = 2'b00,
    RSP_ERROR = 2'b01,
    RSP_RETRY = 2'b10,
    RSP_SPLIT = 2'b11
  } rsp_e;

  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_BUSY = 2'b01;
  localparam logic [1:0] TR_NSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ  = 2'b11;

  typedef enum logic [1:0] {
    DS_OK   = 2'b00,
    DS_ERR1 = 2'b01,
    DS_ERR2 = 2'b10
  } dstate_e;

endpackage

// File: rtl/ahbl_sel_decode.sv
module ahbl_sel_decode #(
  parameter int NUM_SLV = 4,
  parameter int ID_W    = 4,
  parameter int FLD_W   = 8,
  parameter logic [NUM_SLV*ID_W-1:0]  SLV_ID    = {NUM_SLV{4'hC}},
  parameter logic [NUM_SLV*FLD_W-1:0] SLV_FIELD = {NUM_SLV{8'h20}}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ID_W-1:0]    board_id,
  input  logic [FLD_W-1:0]   fld,
  output logic [NUM_SLV-1:0] hsel,
  output logic               hsel_dflt
);

  logic [NUM_SLV-1:0] hit;

  for (genvar i = 0; i < NUM_SLV; i++) begin : g_cmp
    assign hit[i] = (board_id == SLV_ID[i*ID_W +: ID_W]) &&
                    (fld == SLV_FIELD[i*FLD_W +: FLD_W]);
  end

  always_comb begin
    logic taken;
    taken = 1'b0;
    hsel  = '0;
    for (int i = 0; i < NUM_SLV; i++) begin
      if (hit[i] && !taken) begin
        hsel[i] = 1'b1;
        taken   = 1'b1;
      end
    end
    hsel_dflt = !taken;
  end

  // R3
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({hsel_dflt, hsel}) == 1);

endmodule

// File: rtl/ahbl_dphase_sel.sv
module ahbl_dphase_sel #(
  parameter int NSEL = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hready,
  input  logic [NSEL-1:0] sel_live,
  output logic [NSEL-1:0] dsel
);

  localparam logic [NSEL-1:0] RST_SEL = {1'b1, {(NSEL-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst)         dsel <= RST_SEL;
    else if (hready) dsel <= sel_live;
  end

  // R4
  dsel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hready |=> $stable(dsel));

  // R8
  dsel_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> dsel == RST_SEL);

endmodule

// File: rtl/ahbl_err_slave.sv
module ahbl_err_slave import ahbl_dec_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              hready,
  input  logic [1:0]        htrans,
  output logic              hreadyout,
  output logic [1:0]        hresp,
  output logic [DATA_W-1:0] hrdata
);

  dstate_e st;
  logic    active;

  assign active = (htrans == TR_NSEQ) || (htrans == TR_SEQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= DS_OK;
    end else begin
      case (st)
        DS_ERR1: st <= DS_ERR2;
        default: st <= (hready && sel && active) ? DS_ERR1 : DS_OK;
      endcase
    end
  end

  assign hreadyout = (st != DS_ERR1);
  assign hresp     = (st == DS_OK) ? RSP_OKAY : RSP_ERROR;
  assign hrdata    = '0;

  // R6
  err_second_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !hreadyout |=> hreadyout && hresp == RSP_ERROR);

  // R6
  err_first_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (hreadyout && hresp == RSP_ERROR) |-> $past(!hreadyout));

endmodule

// File: rtl/ahbl_rsp_mux.sv
module ahbl_rsp_mux #(
  parameter int NSEL   = 5,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSEL-1:0]        dsel,
  input  logic [NSEL*DATA_W-1:0] rdata_in,
  input  logic [NSEL-1:0]        rdy_in,
  input  logic [2*NSEL-1:0]      rsp_in,
  output logic [DATA_W-1:0]      hrdata,
  output logic                   hready,
  output logic [1:0]             hresp
);

  always_comb begin
    hrdata = '0;
    hready = 1'b0;
    hresp  = 2'b00;
    for (int i = 0; i < NSEL; i++) begin
      hrdata = hrdata | ({DATA_W{dsel[i]}} & rdata_in[i*DATA_W +: DATA_W]);
      hready = hready | (dsel[i] & rdy_in[i]);
      hresp  = hresp  | ({2{dsel[i]}} & rsp_in[2*i +: 2]);
    end
  end

  // R5
  dsel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(dsel) == 1);

endmodule

// File: rtl/ahbl_central_dec.sv
module ahbl_central_dec import ahbl_dec_pkg::*; #(
  parameter int NUM_SLV = 4,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 4,
  parameter int FLD_LSB = 20,
  parameter int FLD_W   = 8,
  parameter logic [NUM_SLV*ID_W-1:0]  SLV_ID    = 16'hCCCC,
  parameter logic [NUM_SLV*FLD_W-1:0] SLV_FIELD = 32'h2322_2120
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ID_W-1:0]           board_id,
  input  logic [ADDR_W-1:0]         haddr,
  input  logic [1:0]                htrans,
  output logic [NUM_SLV-1:0]        hsel,
  input  logic [NUM_SLV*DATA_W-1:0] s_hrdata,
  input  logic [NUM_SLV-1:0]        s_hreadyout,
  input  logic [2*NUM_SLV-1:0]      s_hresp,
  output logic [DATA_W-1:0]         hrdata,
  output logic                      hready,
  output logic [1:0]                hresp
);

  localparam int NSEL = NUM_SLV + 1;

  logic              hsel_dflt;
  logic [NSEL-1:0]   dsel;
  logic              dflt_rdy;
  logic [1:0]        dflt_rsp;
  logic [DATA_W-1:0] dflt_rdata;
  logic              unused_addr;

  assign unused_addr = ^haddr;

  ahbl_sel_decode #(
    .NUM_SLV(NUM_SLV), .ID_W(ID_W), .FLD_W(FLD_W),
    .SLV_ID(SLV_ID), .SLV_FIELD(SLV_FIELD)
  ) u_dec (
    .clk(clk), .rst(rst), .board_id(board_id),
    .fld(haddr[FLD_LSB +: FLD_W]),
    .hsel(hsel), .hsel_dflt(hsel_dflt)
  );

  ahbl_dphase_sel #(.NSEL(NSEL)) u_dsel (
    .clk(clk), .rst(rst), .hready(hready),
    .sel_live({hsel_dflt, hsel}), .dsel(dsel)
  );

  ahbl_err_slave #(.DATA_W(DATA_W)) u_dflt (
    .clk(clk), .rst(rst), .sel(hsel_dflt), .hready(hready),
    .htrans(htrans), .hreadyout(dflt_rdy), .hresp(dflt_rsp),
    .hrdata(dflt_rdata)
  );

  ahbl_rsp_mux #(.NSEL(NSEL), .DATA_W(DATA_W)) u_mux (
    .clk(clk), .rst(rst), .dsel(dsel),
    .rdata_in({dflt_rdata, s_hrdata}),
    .rdy_in({dflt_rdy, s_hreadyout}),
    .rsp_in({dflt_rsp, s_hresp}),
    .hrdata(hrdata), .hready(hready), .hresp(hresp)
  );

  // R8
  reset_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> hready && hresp == RSP_OKAY);

endmodule

// File: tb/ahbl_central_dec_test.sv
module ahbl_central_dec_test;

  localparam int PERIOD = 10;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  board_id = '0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic [NS-1:0]    hsel;
  logic [NS*32-1:0] s_hrdata;
  logic [NS-1:0]    s_hreadyout;
  logic [2*NS-1:0]  s_hresp;
  logic [31:0] hrdata;
  logic        hready;
  logic [1:0]  hresp;

  logic [31:0] sd  [NS];
  logic        rdy [NS];
  logic [1:0]  rsp [NS];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] d;
    logic        r;
    logic [1:0]  p;
    string       tag;
  } exp_t;
  exp_t expq[$];

  int m_cur = NS;
  int m_st  = 0;

  always #(PERIOD/2) clk = ~clk;

  for (genvar i = 0; i < NS; i++) begin : g_slv
    assign s_hrdata[i*32 +: 32] = sd[i];
    assign s_hreadyout[i]       = rdy[i];
    assign s_hresp[2*i +: 2]    = rsp[i];
  end

  ahbl_central_dec #(
    .NUM_SLV(NS), .SLV_ID(16'hC3CC), .SLV_FIELD(32'h2121_2120)
  ) uut (
    .clk(clk), .rst(rst), .board_id(board_id), .haddr(haddr),
    .htrans(htrans), .hsel(hsel), .s_hrdata(s_hrdata),
    .s_hreadyout(s_hreadyout), .s_hresp(s_hresp),
    .hrdata(hrdata), .hready(hready), .hresp(hresp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int decode(input logic [3:0] id, input logic [31:0] a);
    logic [15:0] ids = 16'hC3CC;
    logic [31:0] flds = 32'h2121_2120;
    for (int i = 0; i < NS; i++)
      if (id == ids[i*4 +: 4] && a[27:20] == flds[i*8 +: 8]) return i;
    return NS;
  endfunction

  function automatic logic [31:0] adr(input logic [7:0] f);
    return {4'h0, f, 20'h00040};
  endfunction

  // one bus cycle: drive address phase, check live select, predict data phase
  task automatic step(input logic [3:0] id, input logic [31:0] a, input logic [1:0] tr,
                      input int set_i, input logic set_v, input string tag);
    exp_t e;
    int d;
    logic cur_rdy;
    logic [NS-1:0] eh;
    @(negedge clk);
    if (set_i >= 0) rdy[set_i] = set_v;
    board_id = id; haddr = a; htrans = tr;
    d = decode(id, a);
    #1;
    eh = '0;
    if (d < NS) eh[d] = 1'b1;
    chk({tag, " hsel"}, 32'(hsel), 32'(eh));
    cur_rdy = (m_cur == NS) ? (m_st != 1) : rdy[m_cur];
    if (cur_rdy) begin
      m_cur = d;
      m_st  = (d == NS && tr[1]) ? 1 : 0;
    end else if (m_cur == NS && m_st == 1) begin
      m_st = 2;
    end
    if (m_cur == NS) begin
      e.d = '0; e.r = (m_st != 1); e.p = (m_st == 0) ? 2'b00 : 2'b01;
    end else begin
      e.d = sd[m_cur]; e.r = rdy[m_cur]; e.p = rsp[m_cur];
    end
    e.tag = tag;
    expq.push_back(e);
  endtask

  // monitor: compare data-phase outputs after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        chk({e.tag, " hrdata"}, hrdata, e.d);
        chk({e.tag, " hready"}, 32'(hready), 32'(e.r));
        chk({e.tag, " hresp"}, 32'(hresp), 32'(e.p));
      end
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin
      sd[i]  = 32'hD000_0000 | (32'(i) * 32'h0000_1111) | 32'h0000_0100;
      rdy[i] = 1'b1;
      rsp[i] = 2'b00;
    end
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    chk("R8 reset hready", 32'(hready), 32'd1);
    chk("R8 reset hresp", 32'(hresp), 32'd0);
    chk("R8 reset hrdata", hrdata, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1: both fields match
    step(4'hC, adr(8'h20), 2'b10, -1, 1'b0, "R1 slave0");
    step(4'h3, adr(8'h21), 2'b11, -1, 1'b0, "R1 slave2");
    // R3: slaves 1 and 3 overlap, lowest index wins
    step(4'hC, adr(8'h21), 2'b10, -1, 1'b0, "R3 overlap");
    // R2: one field mismatching -> default; R7 IDLE/BUSY OKAY
    step(4'hC, adr(8'h22), 2'b00, -1, 1'b0, "R2 R7 region miss idle");
    step(4'h3, adr(8'h20), 2'b01, -1, 1'b0, "R2 R7 id miss busy");
    step(4'h5, adr(8'h21), 2'b00, -1, 1'b0, "R2 id miss");
    // R6: unmapped NONSEQ then held address
    step(4'hC, adr(8'h22), 2'b10, -1, 1'b0, "R6 nseq first");
    step(4'hC, adr(8'h20), 2'b10, -1, 1'b0, "R6 nseq second");
    step(4'hC, adr(8'h20), 2'b10, -1, 1'b0, "R6 after error");
    // R6: unmapped SEQ, then back-to-back unmapped NONSEQ
    step(4'hC, adr(8'h7F), 2'b11, -1, 1'b0, "R6 seq first");
    step(4'hC, adr(8'h7F), 2'b11, -1, 1'b0, "R6 seq second");
    step(4'h0, adr(8'h00), 2'b10, -1, 1'b0, "R6 b2b first");
    step(4'hC, adr(8'h21), 2'b10, -1, 1'b0, "R6 b2b second");
    step(4'hC, adr(8'h21), 2'b10, -1, 1'b0, "R5 after error");
    // R4 R5: slave 1 stalls while live decode points elsewhere
    step(4'hC, adr(8'h20), 2'b10, -1, 1'b0, "R5 slave0");
    step(4'hC, adr(8'h21), 2'b10, 1, 1'b0, "R4 stall begin");
    step(4'hC, adr(8'h20), 2'b10, -1, 1'b0, "R4 R5 stall hold");
    step(4'hC, adr(8'h7F), 2'b10, -1, 1'b0, "R4 R5 stall hold2");
    step(4'h3, adr(8'h21), 2'b10, 1, 1'b1, "R4 release");
    // R9: response codes forwarded unchanged
    rsp[0] = 2'b01;
    step(4'hC, adr(8'h20), 2'b10, -1, 1'b0, "R9 error code");
    rsp[1] = 2'b10;
    step(4'hC, adr(8'h21), 2'b10, -1, 1'b0, "R9 retry code");
    rsp[2] = 2'b11;
    step(4'h3, adr(8'h21), 2'b10, -1, 1'b0, "R9 split code");
    step(4'h0, adr(8'h00), 2'b00, -1, 1'b0, "R7 idle end");
    repeat (3) @(posedge clk);
    #2;
    chk("R5 queue drained", 32'(expq.size()), 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule